// File: doc/BRIEF.md
# Vector Swizzle Permutation Unit

This unit reorders the lanes of a four-lane vector according to a packed control word. Each output lane is a copy of one chosen source element. The unit has two source inputs: a primary vector, and a secondary group of four elements that can hold a second vector or four constants. A length field in the control word sets the output to 1, 2, 3 or 4 lanes. Lanes beyond that length read as zero, and a per-lane mask marks which lanes are live. Any source element may be copied into more than one lane.

A mode input selects how the control word is read.

- **Wide mode** uses 14 bits. Each lane has a 3-bit selector that can reach all eight elements across both sources.
- **Compact mode** uses only the low 10 bits. Each lane has a 2-bit selector that reaches only the primary vector.

Results pass through one registered output stage with a valid/ready handshake. This stage is a two-state machine:

- `OS_EMPTY` means no result is held. On an accepted input (transition `FILL`) it moves to `OS_FULL`.
- In `OS_FULL`, the stage takes one of three transitions:
  - `REFILL`: the consumer takes the result and a new input is accepted in the same cycle. The stage stays in `OS_FULL`.
  - `DRAIN`: the consumer takes the result and no input arrives. The stage returns to `OS_EMPTY`.
  - `STALL`: the consumer is not ready. The stage holds the result and stays in `OS_FULL`.

Top module: `vec_swizzle_unit`

## Requirements
- R1: After reset, out_valid is 0, and in_ready is 1 even while out_ready is 0.
- R2: In wide mode (in_wide=1), the selector for lane i is in_ctrl[2+3i+2 : 2+3i]. Values 0 to 3 pick element 0 to 3 of in_vec_a. Values 4 to 7 pick element 0 to 3 of in_vec_b. Element k of a vector is bits [k*W+W-1 : k*W].
- R3: In compact mode (in_wide=0), the selector for lane i is in_ctrl[2+2i+1 : 2+2i]. It picks element 0 to 3 of in_vec_a. Bits in_ctrl[13:10] and the whole of in_vec_b have no effect on the result.
- R4: in_ctrl[1:0] sets the output length: 00 means 1 lane, 01 means 2, 10 means 3 and 11 means 4. out_mask bit i is 1 exactly for lanes below that length. Lanes outside the length are output as zero.
- R5: An input is accepted when in_valid and in_ready are both 1 at a rising edge. Its result appears on out_vec and out_mask, with out_valid=1, right after that edge.
- R6: in_ready equals 1 whenever out_valid is 0 or out_ready is 1, and equals 0 otherwise.
- R7: While out_valid=1 and out_ready=0, out_valid, out_vec and out_mask hold their values across the edge.
- R8: Several output lanes may select the same source element, and each such lane receives a copy of it.
- R9: When out_valid=1, out_ready=1 and in_valid=0 at an edge, out_valid becomes 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input request is present |
| in_ready | output | 1 | Unit can take an input this cycle |
| in_wide | input | 1 | 1 = 14-bit wide control, 0 = 10-bit compact control |
| in_ctrl | input | 14 | Packed control: length in [1:0], then lane selectors 0 to 3 |
| in_vec_a | input | 4*W | Primary source vector |
| in_vec_b | input | 4*W | Secondary source (second vector or constants) |
| out_valid | output | 1 | Registered result is present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_vec | output | 4*W | Permuted result, inactive lanes zero |
| out_mask | output | 4 | Live-lane mask derived from the length field |

## Verification
Directed words do three jobs:

- A wide word whose lanes mix primary and secondary selectors shows whether the high selector bit is decoded as the source choice.
- A wide word that pulls only from the secondary source separates that path from the primary one.
- A compact word with ones in its unused top bits and random secondary data shows that those inputs are really ignored.

Each length code is tried once, so an off-by-one in the mask or in lane zeroing shows up. A word that copies one element into every lane covers duplication. Directed stall and drain sequences tell the `STALL` transition apart from `REFILL` and `DRAIN`. Random words and random consumer readiness then mix all modes and transitions, each checked against a bench model.

// File: rtl/vswz_pkg.sv
package vswz_pkg;
    localparam int LANES  = 4;
    localparam int SEL_W  = 3;
    localparam int CNT_W  = 2;
    localparam int CTRL_W = CNT_W + LANES * SEL_W;
    localparam int NSEL_W = 2;

    typedef enum logic {
        OS_EMPTY = 1'b0,
        OS_FULL  = 1'b1
    } ostage_e;

    typedef struct packed {
        logic [CNT_W-1:0]            cnt;
        logic [LANES-1:0][SEL_W-1:0] sel;
    } swz_ctl_t;
endpackage

// File: rtl/vswz_decode.sv
module vswz_decode
    import vswz_pkg::*;
(
    input  logic              wide,
    input  logic [CTRL_W-1:0] ctrl,
    output swz_ctl_t          ctl
);
    assign ctl.cnt = ctrl[CNT_W-1:0];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            if (wide) begin
                ctl.sel[i] = ctrl[CNT_W + SEL_W*i +: SEL_W];
            end else begin
                ctl.sel[i] = {1'b0, ctrl[CNT_W + NSEL_W*i +: NSEL_W]};
            end
        end
    end
endmodule

// File: rtl/vswz_lane_mux.sv
module vswz_lane_mux
    import vswz_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [LANES*W-1:0] vec_a,
    input  logic [LANES*W-1:0] vec_b,
    input  swz_ctl_t           ctl,
    output logic [LANES*W-1:0] vec_o,
    output logic [LANES-1:0]   mask_o
);
    logic [LANES-1:0][W-1:0] a_l;
    logic [LANES-1:0][W-1:0] b_l;
    logic [LANES-1:0][W-1:0] r_l;

    assign a_l   = vec_a;
    assign b_l   = vec_b;
    assign vec_o = r_l;

    always_comb begin
        unique case (ctl.cnt)
            2'b00: mask_o = 4'b0001;
            2'b01: mask_o = 4'b0011;
            2'b10: mask_o = 4'b0111;
            2'b11: mask_o = 4'b1111;
            default: mask_o = 4'b0000;
        endcase
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [SEL_W-1:0] s;
        logic [W-1:0]     src;
        assign s = ctl.sel[i];
        always_comb begin
            src    = s[SEL_W-1] ? b_l[s[1:0]] : a_l[s[1:0]];
            r_l[i] = mask_o[i] ? src : '0;
        end
    end
endmodule

// File: rtl/vswz_out_stage.sv
module vswz_out_stage
    import vswz_pkg::*;
#(
    parameter int W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [LANES*W-1:0] d_vec,
    input  logic [LANES-1:0]   d_mask,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [LANES*W-1:0] out_vec,
    output logic [LANES-1:0]   out_mask
);
    ostage_e state_q;
    ostage_e state_d;
    logic    load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OS_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OS_EMPTY: begin
                if (in_valid) state_d = OS_FULL;               // FILL
            end
            OS_FULL: begin
                if (out_ready && in_valid)  state_d = OS_FULL;  // REFILL
                else if (out_ready)         state_d = OS_EMPTY; // DRAIN
                else                        state_d = OS_FULL;  // STALL
            end
            default: state_d = OS_EMPTY;
        endcase
    end

    always_comb begin
        out_valid = (state_q == OS_FULL);
        in_ready  = (state_q == OS_EMPTY) || out_ready;
        load      = in_valid && in_ready;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vec  <= '0;
            out_mask <= '0;
        end else if (load) begin
            out_vec  <= d_vec;
            out_mask <= d_mask;
        end
    end
endmodule

// File: rtl/vec_swizzle_unit.sv
module vec_swizzle_unit
    import vswz_pkg::*;
#(
    parameter int W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic               in_wide,
    input  logic [CTRL_W-1:0]  in_ctrl,
    input  logic [LANES*W-1:0] in_vec_a,
    input  logic [LANES*W-1:0] in_vec_b,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [LANES*W-1:0] out_vec,
    output logic [LANES-1:0]   out_mask
);
    swz_ctl_t           ctl;
    logic [LANES*W-1:0] perm_vec;
    logic [LANES-1:0]   perm_mask;

    vswz_decode u_dec (
        .wide (in_wide),
        .ctrl (in_ctrl),
        .ctl  (ctl)
    );

    vswz_lane_mux #(.W(W)) u_mux (
        .vec_a  (in_vec_a),
        .vec_b  (in_vec_b),
        .ctl    (ctl),
        .vec_o  (perm_vec),
        .mask_o (perm_mask)
    );

    vswz_out_stage #(.W(W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .d_vec     (perm_vec),
        .d_mask    (perm_mask),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_vec   (out_vec),
        .out_mask  (out_mask)
    );
endmodule

// File: rtl/vswz_checker.sv
module vswz_checker
    import vswz_pkg::*;
#(
    parameter int W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic               out_valid,
    input logic               out_ready,
    input logic [LANES*W-1:0] out_vec,
    input logic [LANES-1:0]   out_mask
);
    p_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    p_ready_rule_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid || out_ready) |-> in_ready);

    p_ready_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_vec) && $stable(out_mask)));

    p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !in_valid) |=> !out_valid);

    p_mask_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_mask == 4'b0001 || out_mask == 4'b0011 ||
                       out_mask == 4'b0111 || out_mask == 4'b1111));

    for (genvar i = 0; i < LANES; i++) begin : g_zero
        p_zero_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !out_mask[i]) |-> (out_vec[i*W +: W] == '0));
    end
endmodule

bind vec_swizzle_unit vswz_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_vec   (out_vec),
    .out_mask  (out_mask)
);

// File: tb/vec_swizzle_unit_tb_top.sv
module vec_swizzle_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;
    localparam int VW = 4 * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic          in_wide = 1'b0;
    logic [13:0]   in_ctrl = '0;
    logic [VW-1:0] in_vec_a = '0;
    logic [VW-1:0] in_vec_b = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [VW-1:0] out_vec;
    logic [3:0]    out_mask;

    int n_chk = 0;
    int n_bad = 0;

    logic          exp_valid = 1'b0;
    logic [VW-1:0] exp_vec = '0;
    logic [3:0]    exp_mask = '0;

    vec_swizzle_unit #(.W(W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_wide   (in_wide),
        .in_ctrl   (in_ctrl),
        .in_vec_a  (in_vec_a),
        .in_vec_b  (in_vec_b),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_vec   (out_vec),
        .out_mask  (out_mask)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [3:0] ref_mask(input logic [1:0] c);
        case (c)
            2'b00:   return 4'b0001;
            2'b01:   return 4'b0011;
            2'b10:   return 4'b0111;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [VW-1:0] ref_vec(input logic wide, input logic [13:0] c,
                                              input logic [VW-1:0] a, input logic [VW-1:0] b);
        logic [VW-1:0] r;
        logic [3:0]    m;
        r = '0;
        m = ref_mask(c[1:0]);
        for (int i = 0; i < 4; i++) begin
            int s;
            if (wide) s = int'(c[2+3*i +: 3]);
            else      s = int'(c[2+2*i +: 2]);
            if (m[i]) begin
                if (s < 4) r[i*W +: W] = a[s*W +: W];
                else       r[i*W +: W] = b[(s-4)*W +: W];
            end
        end
        return r;
    endfunction

    function automatic logic [VW-1:0] rand_vec();
        logic [VW-1:0] v;
        for (int i = 0; i < 4; i++) v[i*W +: W] = W'($urandom);
        return v;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic cycle(input logic v, input logic wide, input logic [13:0] c,
                         input logic [VW-1:0] a, input logic [VW-1:0] b,
                         input logic rdy, input string dtag);
        logic acc;
        string vtag;
        @(negedge clk);
        in_valid  = v;
        in_wide   = wide;
        in_ctrl   = c;
        in_vec_a  = a;
        in_vec_b  = b;
        out_ready = rdy;
        #1;
        check(in_ready == (!exp_valid || rdy), "R6", "in_ready",
              VW'(in_ready), VW'(!exp_valid || rdy));
        acc = v && in_ready;
        @(posedge clk);
        #1;
        if (acc) begin
            exp_valid = 1'b1;
            exp_vec   = ref_vec(wide, c, a, b);
            exp_mask  = ref_mask(c[1:0]);
            vtag      = "R5";
        end else if (rdy) begin
            exp_valid = 1'b0;
            vtag      = "R9";
        end else begin
            vtag      = "R7";
            dtag      = "R7";
        end
        check(out_valid == exp_valid, vtag, "out_valid",
              VW'(out_valid), VW'(exp_valid));
        if (exp_valid) begin
            check(out_vec == exp_vec, dtag, "out_vec", out_vec, exp_vec);
            check(out_mask == exp_mask, "R4", "out_mask",
                  VW'(out_mask), VW'(exp_mask));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [VW-1:0] a;
        logic [VW-1:0] b;
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check(out_valid == 1'b0, "R1", "out_valid", VW'(out_valid), '0);
        check(in_ready == 1'b1, "R1", "in_ready", VW'(in_ready), VW'(1));
        @(negedge clk);
        rst_n = 1'b1;

        // R2: wide mix of primary and secondary, lanes sel 7,0,5,2
        a = rand_vec(); b = rand_vec();
        cycle(1'b1, 1'b1, {3'd2, 3'd5, 3'd0, 3'd7, 2'b11}, a, b, 1'b1, "R2");
        // R2: wide, secondary only
        a = rand_vec(); b = rand_vec();
        cycle(1'b1, 1'b1, {3'd4, 3'd5, 3'd6, 3'd7, 2'b11}, a, b, 1'b1, "R2");
        // R3: compact with top bits set, random b
        a = rand_vec(); b = rand_vec();
        cycle(1'b1, 1'b0, {4'hF, 2'd0, 2'd1, 2'd2, 2'd3, 2'b11}, a, b, 1'b1, "R3");
        // R4: each length code
        for (int k = 0; k < 4; k++) begin
            a = rand_vec(); b = rand_vec();
            cycle(1'b1, 1'b1, {3'd1, 3'd6, 3'd3, 3'd4, 2'(k)}, a, b, 1'b1, "R4");
        end
        // R8: one element copied to all lanes, both modes
        a = rand_vec(); b = rand_vec();
        cycle(1'b1, 1'b0, {4'h0, 2'd2, 2'd2, 2'd2, 2'd2, 2'b11}, a, b, 1'b1, "R8");
        cycle(1'b1, 1'b1, {3'd5, 3'd5, 3'd5, 3'd5, 2'b11}, a, b, 1'b1, "R8");
        // R7: stall with new input pending
        a = rand_vec(); b = rand_vec();
        cycle(1'b1, 1'b1, {3'd3, 3'd2, 3'd1, 3'd0, 2'b10}, a, b, 1'b0, "R5");
        cycle(1'b1, 1'b1, 14'h1FFF, rand_vec(), rand_vec(), 1'b0, "R7");
        cycle(1'b1, 1'b0, 14'h0ABC, rand_vec(), rand_vec(), 1'b0, "R7");
        // R9: drain
        cycle(1'b0, 1'b0, 14'h0, rand_vec(), rand_vec(), 1'b1, "R9");
        cycle(1'b0, 1'b0, 14'h0, rand_vec(), rand_vec(), 1'b1, "R9");

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            logic wide;
            wide = 1'($urandom);
            cycle(1'($urandom_range(0, 3) != 0), wide, 14'($urandom),
                  rand_vec(), rand_vec(), 1'($urandom_range(0, 2) != 0),
                  wide ? "R2" : "R3");
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule